// File: doc/BRIEF.md
# Configuration-Mode Unlock Key Detector

This block listens to byte writes on an ISA-style I/O bus and opens a small configuration register window only after a two-stage unlock sequence. Stage one is a four-byte pre-key written to a fixed port. Its last two bytes choose one of three base ports. Stage two is a 32-byte key written to that base port. The key bytes come from a shift-register rule, so the block stores no key table. A write that breaks the sequence drops the detector back to idle. The one exception is the opening byte of the pre-key, which starts stage one again.

Once unlocked, the base port acts as an index register and the port just above it acts as a data register. Through this window software selects a logical device number, sets the per-device enables and picks the input clock. Writing the control register with its exit bit set locks the window again. Register contents survive locking and unlocking and are cleared only by reset.

Top module: `cfgkey_unlock`

## Requirements
- R1: After reset, `cfg_active` is 0, `cfg_base` is 0x0000, `ldn` is 0x00, `dev_enable` is 0x00, `clk_ctl` is 0x00 and `clk_sel_48` is 0.
- R2: The pre-key is four writes to port 0x0279: 0x86, then 0x80, then two selector bytes. The selector pair (0x55,0x55) sets `cfg_base` to 0x03F0, (0x55,0xAA) sets it to 0x03BD and (0xAA,0x55) sets it to 0x0370. `cfg_base` changes on the clock edge of the fourth write and stays fixed while `cfg_active` is 1.
- R3: The selector pair (0xAA,0xAA), or any other selector value, completes no pre-key. `cfg_base` keeps its previous value, and a key written afterwards does not set `cfg_active`.
- R4: After a valid pre-key, 32 writes to `cfg_base` must carry the key. The first key byte is 0x6A. Each later byte is the previous byte shifted right by one, with bit0 XOR bit1 of the previous byte placed in bit 7. `cfg_active` rises on the clock edge of the 32nd correct write and not before.
- R5: During either stage, a write with the wrong data or to the wrong port returns the detector to idle. If that write is 0x86 to port 0x0279, stage one restarts with that write counted as its first byte.
- R6: While `cfg_active` is 1, a write to `cfg_base` loads the index, and a write to `cfg_base`+1 writes the register that the index selects.
- R7: Register 0x07 loads `ldn` when the written value is 0x00 to 0x05. Any other value leaves `ldn` unchanged.
- R8: Register 0x23 drives `dev_enable`: bit 0 floppy, bit 1 serial 1, bit 2 serial 2, bit 3 parallel, bit 4 infrared. Bits 7:5 are always 0.
- R9: Register 0x24 is stored whole in `clk_ctl`. `clk_sel_48` equals its bit 1 (0 selects 24 MHz, 1 selects 48 MHz).
- R10: A data write to register 0x02 with bit 1 set clears `cfg_active` on that clock edge. With bit 1 clear, the write has no effect.
- R11: While `cfg_active` is 0, writes to the index and data ports change no register. Register values persist across exit and re-entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle I/O write strobe |
| wr_port | input | 16 | I/O port address of the write |
| wr_data | input | 8 | Data byte of the write |
| cfg_active | output | 1 | Configuration window is open |
| cfg_base | output | 16 | Base port chosen by the last valid pre-key |
| ldn | output | 8 | Selected logical device number |
| dev_enable | output | 8 | Per-device enables, bits 7:5 zero |
| clk_ctl | output | 8 | Clock/suspend control register |
| clk_sel_48 | output | 1 | Input clock select, 1 for 48 MHz |

## Verification
Every result in this block is registered exactly once, so each output reflects a write on the first rising edge that samples its strobe. The bench drives each write on a falling edge, holds the strobe through one rising edge, and samples on the following falling edge, half a cycle after the update. Sequence checks are made both just before the final key byte, where `cfg_active` must still be 0, and just after it, where it must be 1. Register checks follow the data-port write directly. The exit check follows the control write in the same way.

// File: rtl/cfgkey_pkg.sv
// Shared constants, state type and key-step function for the unlock detector.
package cfgkey_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE1,
        ST_PRE2,
        ST_PRE3,
        ST_KEY,
        ST_CFG
    } seq_state_t;

    localparam logic [7:0] PRE_B0   = 8'h86;
    localparam logic [7:0] PRE_B1   = 8'h80;
    localparam logic [7:0] SEL_LO   = 8'h55;
    localparam logic [7:0] SEL_HI   = 8'hAA;

    localparam logic [7:0] IDX_CTRL  = 8'h02;
    localparam logic [7:0] IDX_LDN   = 8'h07;
    localparam logic [7:0] IDX_DEVEN = 8'h23;
    localparam logic [7:0] IDX_CLK   = 8'h24;

    // Next key byte: shift right, feedback bit0^bit1 into bit 7.
    function automatic logic [7:0] key_step(input logic [7:0] b);
        return {b[0] ^ b[1], b[7:1]};
    endfunction

endpackage

// File: rtl/cfgkey_keygen.sv
// Key byte generator for stage two of the unlock sequence.
// Holds the expected key byte and its position. Assumes the caller pulses
// `step` only when the current byte matched, and holds `seed` whenever the
// sequencer is not in the key stage.
module cfgkey_keygen #(
    parameter int         KEY_LEN  = 32,
    parameter logic [7:0] KEY_SEED = 8'h6A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed,
    input  logic       step,
    output logic [7:0] key_byte,
    output logic       key_last
);
    import cfgkey_pkg::*;

    localparam int CW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

    logic [7:0]    byte_q;
    logic [CW-1:0] cnt_q;

    // Expected byte and position: reload on seed, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n || seed) begin
            byte_q <= KEY_SEED;
            cnt_q  <= '0;
        end else if (step) begin
            byte_q <= key_step(byte_q);
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign key_byte = byte_q;
    assign key_last = (cnt_q == CW'(KEY_LEN - 1));

    // R4: the first byte after a seed is always the seed value.
    assert_seed_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (key_byte == KEY_SEED));

endmodule

// File: rtl/cfgkey_seq.sv
// Unlock sequencer: walks the fixed-port pre-key, latches the chosen base
// port, checks the generated key at that base and holds configuration mode
// until the register file requests exit. Assumes one write per strobe cycle.
module cfgkey_seq #(
    parameter int              ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] PREKEY_PORT = 16'h0279,
    parameter logic [ADDR_W-1:0] BASE_A      = 16'h03F0,
    parameter logic [ADDR_W-1:0] BASE_B      = 16'h03BD,
    parameter logic [ADDR_W-1:0] BASE_C      = 16'h0370,
    parameter int              KEY_LEN     = 32,
    parameter logic [7:0]      KEY_SEED    = 8'h6A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_port,
    input  logic [7:0]        wr_data,
    input  logic              exit_req,
    output logic              cfg_active,
    output logic [ADDR_W-1:0] cfg_base
);
    import cfgkey_pkg::*;

    seq_state_t        state_q, state_d;
    seq_state_t        fallback;
    logic              first_lo_q, first_lo_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic              step;
    logic              on_pre, is_sel;
    logic [7:0]        key_byte;
    logic              key_last;

    cfgkey_keygen #(
        .KEY_LEN  (KEY_LEN),
        .KEY_SEED (KEY_SEED)
    ) u_keygen (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed     (state_q != ST_KEY),
        .step     (step),
        .key_byte (key_byte),
        .key_last (key_last)
    );

    // Next-state logic for the two unlock stages and config mode.
    always_comb begin
        state_d    = state_q;
        first_lo_d = first_lo_q;
        base_d     = base_q;
        step       = 1'b0;
        on_pre     = (wr_port == PREKEY_PORT);
        is_sel     = (wr_data == SEL_LO) || (wr_data == SEL_HI);
        fallback   = (on_pre && wr_data == PRE_B0) ? ST_PRE1 : ST_IDLE;
        if (wr_stb) begin
            unique case (state_q)
                ST_IDLE: state_d = fallback;
                ST_PRE1: state_d = (on_pre && wr_data == PRE_B1) ? ST_PRE2 : fallback;
                ST_PRE2: begin
                    if (on_pre && is_sel) begin
                        state_d    = ST_PRE3;
                        first_lo_d = (wr_data == SEL_LO);
                    end else begin
                        state_d = fallback;
                    end
                end
                ST_PRE3: begin
                    if (on_pre && is_sel && (first_lo_q || wr_data == SEL_LO)) begin
                        state_d = ST_KEY;
                        if (!first_lo_q)
                            base_d = BASE_C;
                        else if (wr_data == SEL_LO)
                            base_d = BASE_A;
                        else
                            base_d = BASE_B;
                    end else begin
                        state_d = fallback;
                    end
                end
                ST_KEY: begin
                    if (wr_port == base_q && wr_data == key_byte) begin
                        step = 1'b1;
                        if (key_last)
                            state_d = ST_CFG;
                    end else begin
                        state_d = fallback;
                    end
                end
                ST_CFG: begin
                    if (exit_req)
                        state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State, selector memory and base port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            first_lo_q <= 1'b0;
            base_q     <= '0;
        end else begin
            state_q    <= state_d;
            first_lo_q <= first_lo_d;
            base_q     <= base_d;
        end
    end

    assign cfg_active = (state_q == ST_CFG);
    assign cfg_base   = base_q;

    // R4: config mode is only entered by the last correct key write.
    assert_enter_on_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_active) |-> $past(wr_stb && wr_port == base_q && key_last));

    // R2: the base port cannot move while the window is open.
    assert_base_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active && $past(cfg_active)) |-> $stable(cfg_base));

    // R5: any strobe-free cycle leaves the sequencer state alone.
    assert_no_strobe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) && $past(rst_n) |-> $stable(state_q));

endmodule

// File: rtl/cfgkey_regs.sv
// Index/data register window opened in configuration mode.
// Holds the index, logical device number, per-device enables and clock
// control, and raises exit_req on a control write with the exit bit.
// Assumes cfg_base is stable while cfg_active is high.
module cfgkey_regs #(
    parameter int ADDR_W  = 16,
    parameter int NUM_DEV = 5,
    parameter int NUM_LDN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_port,
    input  logic [7:0]        wr_data,
    input  logic              cfg_active,
    input  logic [ADDR_W-1:0] cfg_base,
    output logic              exit_req,
    output logic [7:0]        index,
    output logic [7:0]        ldn,
    output logic [7:0]        dev_enable,
    output logic [7:0]        clk_ctl
);
    import cfgkey_pkg::*;

    logic       idx_wr, dat_wr;
    logic [7:0] index_q, ldn_q, clk_q, en_q;

    assign idx_wr = wr_stb && cfg_active && (wr_port == cfg_base);
    assign dat_wr = wr_stb && cfg_active && (wr_port == cfg_base + ADDR_W'(1));

    // Index register: written through the base port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (idx_wr)
            index_q <= wr_data;
    end

    // Logical device select: only in-range numbers are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ldn_q <= '0;
        else if (dat_wr && index_q == IDX_LDN && wr_data < 8'(NUM_LDN))
            ldn_q <= wr_data;
    end

    // Clock/suspend control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_q <= '0;
        else if (dat_wr && index_q == IDX_CLK)
            clk_q <= wr_data;
    end

    // Per-device enable bits; positions above NUM_DEV are reserved zeros.
    for (genvar g = 0; g < 8; g++) begin : g_en
        if (g < NUM_DEV) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    en_q[g] <= 1'b0;
                else if (dat_wr && index_q == IDX_DEVEN)
                    en_q[g] <= wr_data[g];
            end
        end else begin : g_rsvd
            assign en_q[g] = 1'b0;
        end
    end

    assign exit_req   = dat_wr && (index_q == IDX_CTRL) && wr_data[1];
    assign index      = index_q;
    assign ldn        = ldn_q;
    assign dev_enable = en_q;
    assign clk_ctl    = clk_q;

    // R7: the device number never leaves its legal range.
    assert_ldn_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ldn_q < 8'(NUM_LDN));

    // R11: with the window closed, no register moves.
    assert_closed_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_active) |-> ($stable(ldn_q) && $stable(clk_q) && $stable(en_q) && $stable(index_q)));

endmodule

// File: rtl/cfgkey_unlock.sv
// Top of the configuration-mode unlock key detector.
// Connects the unlock sequencer to the register window. Assumes a single
// write per strobe cycle on a 16-bit I/O address bus.
module cfgkey_unlock #(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] PREKEY_PORT = 16'h0279,
    parameter logic [ADDR_W-1:0] BASE_A      = 16'h03F0,
    parameter logic [ADDR_W-1:0] BASE_B      = 16'h03BD,
    parameter logic [ADDR_W-1:0] BASE_C      = 16'h0370,
    parameter int                KEY_LEN     = 32,
    parameter logic [7:0]        KEY_SEED    = 8'h6A,
    parameter int                NUM_DEV     = 5,
    parameter int                NUM_LDN     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_port,
    input  logic [7:0]        wr_data,
    output logic              cfg_active,
    output logic [ADDR_W-1:0] cfg_base,
    output logic [7:0]        ldn,
    output logic [7:0]        dev_enable,
    output logic [7:0]        clk_ctl,
    output logic              clk_sel_48
);
    import cfgkey_pkg::*;

    logic       exit_req;
    logic [7:0] index;

    cfgkey_seq #(
        .ADDR_W      (ADDR_W),
        .PREKEY_PORT (PREKEY_PORT),
        .BASE_A      (BASE_A),
        .BASE_B      (BASE_B),
        .BASE_C      (BASE_C),
        .KEY_LEN     (KEY_LEN),
        .KEY_SEED    (KEY_SEED)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_port    (wr_port),
        .wr_data    (wr_data),
        .exit_req   (exit_req),
        .cfg_active (cfg_active),
        .cfg_base   (cfg_base)
    );

    cfgkey_regs #(
        .ADDR_W  (ADDR_W),
        .NUM_DEV (NUM_DEV),
        .NUM_LDN (NUM_LDN)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_port    (wr_port),
        .wr_data    (wr_data),
        .cfg_active (cfg_active),
        .cfg_base   (cfg_base),
        .exit_req   (exit_req),
        .index      (index),
        .ldn        (ldn),
        .dev_enable (dev_enable),
        .clk_ctl    (clk_ctl)
    );

    assign clk_sel_48 = clk_ctl[1];

    // R10: leaving config mode needs a control write with the exit bit.
    assert_exit_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_active) |-> $past(wr_stb && wr_port == cfg_base + ADDR_W'(1)
                                    && index == IDX_CTRL && wr_data[1]));

endmodule

// File: tb/cfgkey_unlock_tb.sv
module cfgkey_unlock_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_port = '0;
    logic [7:0]  wr_data = '0;
    logic        cfg_active;
    logic [15:0] cfg_base;
    logic [7:0]  ldn, dev_enable, clk_ctl;
    logic        clk_sel_48;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [7:0] m_ldn = 8'h00, m_en = 8'h00, m_clk = 8'h00;

    always #10 clk = ~clk;

    cfgkey_unlock u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_port(wr_port),
        .wr_data(wr_data), .cfg_active(cfg_active), .cfg_base(cfg_base),
        .ldn(ldn), .dev_enable(dev_enable), .clk_ctl(clk_ctl),
        .clk_sel_48(clk_sel_48)
    );

    function automatic logic [7:0] nxt(input logic [7:0] b);
        return {b[0] ^ b[1], b[7:1]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write: driven on a falling edge, sampled at the next falling edge.
    task automatic wr(input logic [15:0] p, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_port = p; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic prekey(input logic [7:0] s0, input logic [7:0] s1);
        wr(16'h0279, 8'h86); wr(16'h0279, 8'h80);
        wr(16'h0279, s0);    wr(16'h0279, s1);
    endtask

    // Write n key bytes to port p; byte at position bad is corrupted.
    task automatic key(input logic [15:0] p, input int bad, input int n);
        logic [7:0] k = 8'h6A;
        for (int i = 0; i < n; i++) begin
            wr(p, (i == bad) ? (k ^ 8'h01) : k);
            if (i == 30) chk("R4 not open before last byte", {31'b0, cfg_active}, 0);
            k = nxt(k);
        end
    endtask

    task automatic reg_wr(input logic [15:0] b, input logic [7:0] idx, input logic [7:0] d);
        wr(b, idx); wr(b + 16'd1, d);
    endtask

    task automatic chk_regs(input string req);
        chk(req, {24'b0, ldn}, {24'b0, m_ldn});
        chk(req, {24'b0, dev_enable}, {24'b0, m_en});
        chk(req, {24'b0, clk_ctl}, {24'b0, m_clk});
        chk(req, {31'b0, clk_sel_48}, {31'b0, m_clk[1]});
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cfg_active", {31'b0, cfg_active}, 0);
        chk("R1 cfg_base", {16'b0, cfg_base}, 0);
        chk_regs("R1 regs");

        // R2 selector 55,55 and R4 full key
        prekey(8'h55, 8'h55);
        chk("R2 base 3F0", {16'b0, cfg_base}, 32'h03F0);
        chk("R2 not open after prekey", {31'b0, cfg_active}, 0);
        key(16'h03F0, -1, 32);
        chk("R4 open after key", {31'b0, cfg_active}, 1);

        // R6 R8 R9 R7 register window
        reg_wr(16'h03F0, 8'h23, 8'hFF); m_en = 8'h1F;
        chk_regs("R8 enables, R6 window");
        reg_wr(16'h03F0, 8'h24, 8'h02); m_clk = 8'h02;
        chk_regs("R9 clock select");
        reg_wr(16'h03F0, 8'h07, 8'h03); m_ldn = 8'h03;
        chk_regs("R7 ldn in range");
        reg_wr(16'h03F0, 8'h07, 8'h06);
        chk_regs("R7 ldn out of range ignored");

        // R10 exit
        reg_wr(16'h03F0, 8'h02, 8'h01);
        chk("R10 bit1 clear keeps mode", {31'b0, cfg_active}, 1);
        wr(16'h03F1, 8'h02);
        chk("R10 exit", {31'b0, cfg_active}, 0);

        // R11 writes while closed are ignored
        reg_wr(16'h03F0, 8'h23, 8'h00);
        reg_wr(16'h03F0, 8'h24, 8'h00);
        chk_regs("R11 closed writes ignored");
        chk("R11 still closed", {31'b0, cfg_active}, 0);

        // R2 selector 55,AA; R5 bad key byte
        prekey(8'h55, 8'hAA);
        chk("R2 base 3BD", {16'b0, cfg_base}, 32'h03BD);
        key(16'h03BD, 5, 32);
        chk("R5 bad key byte", {31'b0, cfg_active}, 0);

        // R5 restart from inside stage one and inside the key
        wr(16'h0279, 8'h86); wr(16'h0279, 8'h80); wr(16'h0279, 8'h55);
        prekey(8'h55, 8'hAA);
        key(16'h03BD, -1, 10);
        prekey(8'h55, 8'hAA);
        key(16'h03BD, -1, 32);
        chk("R5 restart then open", {31'b0, cfg_active}, 1);
        chk_regs("R11 persist across re-entry");
        reg_wr(16'h03BD, 8'h02, 8'h02);
        chk("R10 exit at 3BD", {31'b0, cfg_active}, 0);

        // R2 selector AA,55; R5 key at wrong port
        prekey(8'hAA, 8'h55);
        chk("R2 base 370", {16'b0, cfg_base}, 32'h0370);
        key(16'h03F0, -1, 32);
        chk("R5 key at wrong port", {31'b0, cfg_active}, 0);
        prekey(8'hAA, 8'h55);
        key(16'h0370, -1, 32);
        chk("R4 open at 370", {31'b0, cfg_active}, 1);

        // R6 R7 R8 R9 random register traffic
        for (int i = 0; i < 150; i++) begin
            logic [7:0] idx, d;
            case ($urandom % 5)
                0: idx = 8'h07;
                1: idx = 8'h23;
                2: idx = 8'h24;
                3: idx = 8'h02;
                default: idx = 8'h40 + 8'($urandom % 16);
            endcase
            d = 8'($urandom);
            if (idx == 8'h02) d[1] = 1'b0;
            reg_wr(16'h0370, idx, d);
            if (idx == 8'h07 && d < 8'd6) m_ldn = d;
            if (idx == 8'h23) m_en = d & 8'h1F;
            if (idx == 8'h24) m_clk = d;
            chk_regs("R6 random register write");
        end
        chk("R10 random no exit", {31'b0, cfg_active}, 1);
        reg_wr(16'h0370, 8'h02, 8'hFF);
        chk("R10 exit at 370", {31'b0, cfg_active}, 0);

        // R3 invalid selector pair
        prekey(8'hAA, 8'hAA);
        chk("R3 base unchanged", {16'b0, cfg_base}, 32'h0370);
        key(16'h0370, -1, 32);
        chk("R3 no entry at 370", {31'b0, cfg_active}, 0);
        key(16'h03F0, -1, 32);
        chk("R3 no entry at 3F0", {31'b0, cfg_active}, 0);

        // R11 random traffic while closed
        for (int i = 0; i < 100; i++) begin
            wr(16'h0400 + 16'($urandom % 1024), 8'($urandom));
            chk("R11 idle traffic", {31'b0, cfg_active}, 0);
        end
        chk_regs("R11 idle traffic regs");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule